// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block guards a small volatile word array that has a shadow copy in a second, nonvolatile array. In normal operation a host reads and writes the volatile array through plain chip-enable, write-enable and output-enable pins. Two events copy the whole volatile array into the shadow. One is an external request line (active low) held down long enough to pass a glitch filter. The other is power-good falling. The copy happens only if some write has landed since the last copy in either direction. When power returns, signalled by a rising edge on the restore input, the shadow is copied back into the volatile array.

A copy moves one word per clock through a word-at-a-time engine, inside a fixed window counted in cycles. While the block is working it pulls the busy output high, which the board uses to hold the shared store/busy wire low. The block then stays locked until the cause goes away. For a line-triggered store that means the request line rising, followed by a recovery delay. For a power-triggered store it means power-good rising. A drain window before each store lets a host write that is already under way land first. All timings are parameters given in clock cycles. Host access is a single-cycle register interface with no back-pressure, so no valid/ready handshake is used.

Top module: `nvsr_sequencer`

## Requirements
- R1: After reset the block is idle: busy_pull is 0, host_rdata_en is 0 while host_ce is 0, the written flag is clear, and both arrays hold zero.
- R2: In the idle state a cycle with host_ce=1 and host_we=1 writes host_wdata to word host_addr. With host_ce=1, host_oe=1, host_we=0 and strobe_n_in=1, host_rdata_en=1 and host_rdata shows the addressed word in the same cycle.
- R3: strobe_n_in held low for at least REQ_MIN_CYC clocks starts a store sequence, and busy_pull rises no later than REQ_MIN_CYC+3 clocks after the line fell. A low pulse of REQ_MIN_CYC-1 clocks is ignored.
- R4: While strobe_n_in is low, host_rdata_en is 0.
- R5: A store sequence begins with DRAIN_CYC busy cycles. Host writes are still accepted during these cycles, and such a write makes the store copy happen.
- R6: A store copies every volatile word to the shadow only if a write has landed since the last copy. A dirty store holds busy_pull for exactly DRAIN_CYC+CYCLE_CYC cycles; a clean one holds it for exactly DRAIN_CYC cycles.
- R7: After a line-triggered store, reads stay disabled while strobe_n_in is low. Once the line rises, normal access returns after a recovery of RECOVER_CYC cycles, and no sooner than RECOVER_CYC+1 cycles after the rise.
- R8: power-good low in the idle state starts a store under the same written-since-last-copy rule. After it, access stays disabled until pwr_good is high again.
- R9: A rising edge on pwr_restore copies every shadow word back to the volatile array, with busy_pull high for exactly CYCLE_CYC cycles.
- R10: Host writes issued while a copy runs do not change either array, and reads are disabled.
- R11: A completed store or recall clears the written flag, so a second store with no write in between is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| host_oe | input | 1 | Host output enable, active high |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid when host_rdata_en is 1 |
| host_rdata_en | output | 1 | Data output drive enable; 0 means high impedance |
| strobe_n_in | input | 1 | Level of the store/busy wire, low requests a store |
| busy_pull | output | 1 | 1 pulls the store/busy wire low while a sequence runs |
| pwr_good | input | 1 | Supply good; low requests an automatic store |
| pwr_restore | input | 1 | Rising edge requests a recall |

## Verification
The bench builds the block with a 16-word array, REQ_MIN_CYC=3, DRAIN_CYC=4, CYCLE_CYC=24 and RECOVER_CYC=5. The real-time defaults would take a million cycles per copy; these values bring each full copy, the drain window, the glitch limit and the recovery delay within a few dozen cycles, so exact busy widths can be counted. With a window only eight cycles longer than the array, an engine that stalls or skips a word shows up in the shadow contents read back after a recall.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_STORE,
    ST_RECALL,
    ST_LOCK,
    ST_RECOVER,
    ST_PWRDN
  } nvsr_state_e;

  typedef enum logic {
    SRC_LINE,
    SRC_POWER
  } nvsr_src_e;
endpackage

// File: rtl/nvsr_req_filter.sv
module nvsr_req_filter #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic active
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);

  logic             s1, s2;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      cnt <= '0;
    end else begin
      s1 <= line_n;
      s2 <= s1;
      if (s2)
        cnt <= '0;
      else if (cnt != CNT_W'(MIN_CYC))
        cnt <= cnt + CNT_W'(1);
    end
  end

  assign active = (cnt == CNT_W'(MIN_CYC));

  // R3
  req_low_before_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !$past(s2));
endmodule

// File: rtl/nvsr_reg_array.sv
module nvsr_reg_array #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvsr_copy_engine.sv
module nvsr_copy_engine #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              act,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else if (start) begin
      act <= 1'b1;
      idx <= '0;
    end else if (act) begin
      if (idx == LAST) act <= 1'b0;
      else             idx <= idx + ADDR_W'(1);
    end
  end

  // R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !start && idx != LAST) |=> (act && idx == $past(idx) + ADDR_W'(1)));
endmodule

// File: rtl/nvsr_sequencer.sv
module nvsr_sequencer
  import nvsr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int REQ_MIN_CYC = 2,
  parameter int DRAIN_CYC   = 100,
  parameter int CYCLE_CYC   = 1000000,
  parameter int RECOVER_CYC = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ce,
  input  logic              host_we,
  input  logic              host_oe,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_en,
  input  logic              strobe_n_in,
  output logic              busy_pull,
  input  logic              pwr_good,
  input  logic              pwr_restore
);
  localparam int TMR_MAX0 = (DRAIN_CYC > RECOVER_CYC) ? DRAIN_CYC : RECOVER_CYC;
  localparam int TMR_MAX  = (CYCLE_CYC > TMR_MAX0) ? CYCLE_CYC : TMR_MAX0;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  nvsr_state_e       state;
  nvsr_src_e         src;
  logic [TMR_W-1:0]  tmr;
  logic              dirty, dirty_next;
  logic              restore_d, recall_pend;
  logic              req_active;
  logic              host_wr, copy_done, eng_start, eng_act;
  logic              in_copy, tmr_zero;
  logic [ADDR_W-1:0] eng_idx;
  logic              vol_we, nv_we;
  logic [ADDR_W-1:0] vol_waddr, vol_raddr;
  logic [DATA_W-1:0] vol_wdata, vol_rd, nv_rd;

  nvsr_req_filter #(.MIN_CYC(REQ_MIN_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .line_n(strobe_n_in), .active(req_active)
  );

  nvsr_copy_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .act(eng_act), .idx(eng_idx)
  );

  nvsr_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vol (
    .clk(clk), .rst_n(rst_n), .we(vol_we), .waddr(vol_waddr), .wdata(vol_wdata),
    .raddr(vol_raddr), .rdata(vol_rd)
  );

  nvsr_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nv (
    .clk(clk), .rst_n(rst_n), .we(nv_we), .waddr(eng_idx), .wdata(vol_rd),
    .raddr(eng_idx), .rdata(nv_rd)
  );

  // host side
  assign host_wr       = host_ce && host_we && (state == ST_IDLE || state == ST_DRAIN);
  assign host_rdata_en = (state == ST_IDLE) && host_ce && host_oe && !host_we && strobe_n_in;
  assign host_rdata    = vol_rd;

  // array port steering
  assign vol_we    = host_wr || (eng_act && state == ST_RECALL);
  assign vol_waddr = eng_act ? eng_idx : host_addr;
  assign vol_wdata = eng_act ? nv_rd : host_wdata;
  assign vol_raddr = eng_act ? eng_idx : host_addr;
  assign nv_we     = eng_act && (state == ST_STORE);

  assign in_copy    = (state == ST_STORE) || (state == ST_RECALL);
  assign tmr_zero   = (tmr == '0);
  assign copy_done  = in_copy && tmr_zero;
  assign dirty_next = dirty || host_wr;
  assign busy_pull  = (state == ST_DRAIN) || in_copy;
  assign eng_start  = (state == ST_DRAIN && tmr_zero && dirty_next) ||
                      (state == ST_IDLE && pwr_good && !req_active && recall_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
    end else if (copy_done) begin
      dirty <= 1'b0;
    end else if (host_wr) begin
      dirty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      src         <= SRC_LINE;
      tmr         <= '0;
      restore_d   <= 1'b0;
      recall_pend <= 1'b0;
    end else begin
      restore_d <= pwr_restore;
      if (pwr_restore && !restore_d) recall_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (!pwr_good) begin
            state <= ST_DRAIN;
            src   <= SRC_POWER;
            tmr   <= TMR_W'(DRAIN_CYC - 1);
          end else if (req_active) begin
            state <= ST_DRAIN;
            src   <= SRC_LINE;
            tmr   <= TMR_W'(DRAIN_CYC - 1);
          end else if (recall_pend) begin
            state       <= ST_RECALL;
            tmr         <= TMR_W'(CYCLE_CYC - 1);
            recall_pend <= 1'b0;
          end
        end
        ST_DRAIN: begin
          if (!tmr_zero) begin
            tmr <= tmr - TMR_W'(1);
          end else if (dirty_next) begin
            state <= ST_STORE;
            tmr   <= TMR_W'(CYCLE_CYC - 1);
          end else begin
            state <= (src == SRC_LINE) ? ST_LOCK : ST_PWRDN;
          end
        end
        ST_STORE: begin
          if (!tmr_zero) tmr <= tmr - TMR_W'(1);
          else           state <= (src == SRC_LINE) ? ST_LOCK : ST_PWRDN;
        end
        ST_RECALL: begin
          if (!tmr_zero) tmr <= tmr - TMR_W'(1);
          else           state <= ST_IDLE;
        end
        ST_LOCK: begin
          if (!req_active) begin
            state <= ST_RECOVER;
            tmr   <= TMR_W'(RECOVER_CYC - 1);
          end
        end
        ST_RECOVER: begin
          if (!tmr_zero) tmr <= tmr - TMR_W'(1);
          else           state <= ST_IDLE;
        end
        ST_PWRDN: begin
          if (pwr_good) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ce && host_we && state == ST_IDLE) |=> dirty);

  // R10
  engine_inside_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_act |-> in_copy);

  // R6
  clean_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && tmr_zero && !dirty && !(host_ce && host_we)) |=> state != ST_STORE);

  // R7
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && req_active) |=> state == ST_LOCK);

  // R11
  dirty_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_copy) && !in_copy) |-> !dirty);

  // R10
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pull |-> !host_rdata_en);
endmodule

// File: tb/nvsr_sequencer_tb.sv
module nvsr_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int REQ_MIN = 3;
  localparam int DRAIN = 4;
  localparam int CYCLE = 24;
  localparam int RECOV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_ce = 1'b0, host_we = 1'b0, host_oe = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_rdata_en;
  logic strobe_n_in = 1'b1;
  logic busy_pull;
  logic pwr_good = 1'b1;
  logic pwr_restore = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int vm [DEPTH];
  int nvm [DEPTH];
  int lat, width;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsr_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .REQ_MIN_CYC(REQ_MIN),
    .DRAIN_CYC(DRAIN), .CYCLE_CYC(CYCLE), .RECOVER_CYC(RECOV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_en(host_rdata_en), .strobe_n_in(strobe_n_in), .busy_pull(busy_pull),
    .pwr_good(pwr_good), .pwr_restore(pwr_restore)
  );

  function automatic int exp_width(bit dirty_store, bit is_recall);
    if (is_recall) return CYCLE;
    return dirty_store ? DRAIN + CYCLE : DRAIN;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(int a, int d);
    @(negedge clk);
    host_ce = 1; host_we = 1; host_oe = 0;
    host_addr = AW'(a); host_wdata = DW'(d);
    @(negedge clk);
    host_ce = 0; host_we = 0;
  endtask

  task automatic read_chk(int a, int exp, string req);
    @(negedge clk);
    host_ce = 1; host_we = 0; host_oe = 1; host_addr = AW'(a);
    #1;
    check(host_rdata_en == 1'b1, req, int'(host_rdata_en), 1);
    check(int'(host_rdata) == exp, req, int'(host_rdata), exp);
    host_ce = 0; host_oe = 0;
  endtask

  task automatic read_blocked(string req);
    @(negedge clk);
    host_ce = 1; host_we = 0; host_oe = 1;
    #1;
    check(host_rdata_en == 1'b0, req, int'(host_rdata_en), 0);
    host_ce = 0; host_oe = 0;
  endtask

  // waits for busy, then counts busy cycles; poke writes one word in the
  // first busy cycle, jam writes random words in every busy cycle
  task automatic measure(bit poke, int poke_a, int poke_d, bit jam);
    lat = 0;
    width = 0;
    forever begin
      @(negedge clk);
      if (busy_pull || lat > 60) break;
      lat++;
    end
    while (busy_pull && width < 300) begin
      width++;
      if (poke && width == 1) begin
        host_ce = 1; host_we = 1; host_addr = AW'(poke_a); host_wdata = DW'(poke_d);
      end else if (jam) begin
        host_ce = 1; host_we = 1;
        host_addr = AW'($urandom_range(DEPTH-1)); host_wdata = DW'($urandom);
      end else begin
        host_ce = 0; host_we = 0;
      end
      @(negedge clk);
    end
    host_ce = 0; host_we = 0;
  endtask

  task automatic release_line(string req);
    int n;
    @(negedge clk);
    strobe_n_in = 1;
    host_ce = 1; host_oe = 1; host_we = 0;
    n = 0;
    forever begin
      @(negedge clk);
      #1;
      if (host_rdata_en || n > 40) break;
      n++;
    end
    host_ce = 0; host_oe = 0;
    check(n >= RECOV + 1 && n <= RECOV + 4, req, n, RECOV + 3);
  endtask

  task automatic line_store(bit exp_dirty, string req, bit poke, int pa, int pd);
    @(negedge clk);
    strobe_n_in = 0;
    measure(poke, pa, pd, 1'b0);
    check(lat <= REQ_MIN + 3, "R3", lat, REQ_MIN + 3);
    check(width == exp_width(exp_dirty, 1'b0), req, width, exp_width(exp_dirty, 1'b0));
  endtask

  task automatic recall_run(string req);
    @(negedge clk);
    pwr_restore = 1;
    @(negedge clk);
    pwr_restore = 0;
    measure(1'b0, 0, 0, 1'b1);
    check(width == exp_width(1'b0, 1'b1), req, width, CYCLE);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin vm[i] = 0; nvm[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(busy_pull == 1'b0, "R1", int'(busy_pull), 0);
    check(host_rdata_en == 1'b0, "R1", int'(host_rdata_en), 0);
    read_chk(7, 0, "R1");
    // R1 written flag clear: first store is clean; R7 lock and recovery
    line_store(1'b0, "R1", 1'b0, 0, 0);
    repeat (8) @(negedge clk);
    read_blocked("R7");
    release_line("R7");

    // R2 random writes then random reads
    for (int i = 0; i < DEPTH; i++) begin
      vm[i] = $urandom_range(255);
      do_write(i, vm[i]);
    end
    for (int k = 0; k < 12; k++) begin
      int a = $urandom_range(DEPTH-1);
      read_chk(a, vm[a], "R2");
    end

    // R3 short pulse ignored
    @(negedge clk);
    strobe_n_in = 0;
    repeat (REQ_MIN - 1) @(negedge clk);
    strobe_n_in = 1;
    begin
      int seen = 0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (busy_pull) seen++;
      end
      check(seen == 0, "R3", seen, 0);
    end
    read_chk(2, vm[2], "R3");

    // R4 outputs off while line low, then R6 dirty store
    @(negedge clk);
    strobe_n_in = 0;
    host_ce = 1; host_oe = 1; host_we = 0;
    #1;
    check(host_rdata_en == 1'b0, "R4", int'(host_rdata_en), 0);
    host_ce = 0; host_oe = 0;
    measure(1'b0, 0, 0, 1'b0);
    check(width == exp_width(1'b1, 1'b0), "R6", width, DRAIN + CYCLE);
    for (int i = 0; i < DEPTH; i++) nvm[i] = vm[i];
    release_line("R7");

    // R11 second store with no write is clean
    line_store(1'b0, "R11", 1'b0, 0, 0);
    release_line("R7");

    // R9 R10 overwrite, recall with jammed writes, shadow returns
    for (int i = 0; i < DEPTH; i++) begin
      vm[i] = (nvm[i] + 1 + $urandom_range(200)) % 256;
      do_write(i, vm[i]);
    end
    read_chk(4, vm[4], "R2");
    recall_run("R9");
    for (int i = 0; i < DEPTH; i++) begin
      read_chk(i, nvm[i], "R10");
      vm[i] = nvm[i];
    end
    // R11 recall cleared the flag even though writes preceded it
    line_store(1'b0, "R11", 1'b0, 0, 0);
    release_line("R7");

    // R5 write in drain window lands and forces the copy
    line_store(1'b1, "R5", 1'b1, 3, 8'h5a ^ vm[3]);
    vm[3] = 8'h5a ^ vm[3];
    for (int i = 0; i < DEPTH; i++) nvm[i] = vm[i];
    release_line("R7");
    read_chk(3, vm[3], "R5");

    // R8 power loss store
    vm[5] = (vm[5] + 77) % 256;
    do_write(5, vm[5]);
    @(negedge clk);
    pwr_good = 0;
    measure(1'b0, 0, 0, 1'b0);
    check(width == exp_width(1'b1, 1'b0), "R8", width, DRAIN + CYCLE);
    for (int i = 0; i < DEPTH; i++) nvm[i] = vm[i];
    repeat (4) @(negedge clk);
    read_blocked("R8");
    pwr_good = 1;
    repeat (3) @(negedge clk);
    read_chk(5, vm[5], "R8");
    do_write(5, 0);
    do_write(0, (vm[0] + 9) % 256);
    recall_run("R9");
    read_chk(5, nvm[5], "R8");
    read_chk(0, nvm[0], "R9");
    // R8 clean power store after recall
    @(negedge clk);
    pwr_good = 0;
    measure(1'b0, 0, 0, 1'b0);
    check(width == exp_width(1'b0, 1'b0), "R8", width, DRAIN);
    pwr_good = 1;
    repeat (3) @(negedge clk);
    read_chk(9, nvm[9], "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule